// File: doc/BRIEF.md
# Shared Two-Port Memory with Mailbox Interrupts

This block is a synchronous word memory with two fully independent access ports, called left and right. Each port has its own enable, write strobe, address, write data and registered read data. It serves as the shared exchange area between a host on the right side and a processor on the left side. By software convention, the upper half of the array carries commands from the host to the processor, and the lower half carries results back to the host. The hardware does not enforce this split.

The two highest word locations double as mailboxes. A write by one port to its outgoing mailbox pulls the interrupt line of the other port low. Any access by the receiving port to that mailbox, read or write, releases the line. The flag logic ignores the data value: software stores nonzero to request and zero to acknowledge, but a stored zero still raises the flag.

The block also watches for same-address accesses in one cycle that involve a write. Such a conflict raises a one-cycle error pulse, and the left port's write takes effect. The production configuration uses `ADDR_W = 13`, which gives 8192 words of 16 bits. The elaborated default is 11 address bits, and all behaviour scales with the parameter.

Top module: `dpram_mailbox`

## Requirements
- R1: A word written through either port (enable and write strobe high) is returned by a later read of that address on either port. The read data appears on the port's read output after the clock edge that samples the read, and that output holds its value in every cycle in which the port does not read.
- R2: Both ports may read the same or different addresses in one cycle. Each port gets the stored word, and no conflict is flagged.
- R3: A left-port write to the all-ones address (top mailbox) drives `r_irq_n` low after that clock edge, whatever data is written, including zero.
- R4: Any right-port access (read or write) to the all-ones address drives `r_irq_n` high after that clock edge.
- R5: A right-port write to the all-ones-minus-one address (second mailbox) drives `l_irq_n` low after that clock edge, whatever data is written.
- R6: Any left-port access (read or write) to the all-ones-minus-one address drives `l_irq_n` high after that clock edge.
- R7: When a mailbox is set by the opposite port's write and accessed by the local port in the same cycle, the interrupt line ends low.
- R8: `clash` is high for exactly the one cycle after a cycle in which both ports are enabled on the same address and at least one of them writes. It is low after any other cycle.
- R9: When both ports write the same address in one cycle, the left data is stored. When one port reads an address while the other writes it, the reader gets the previous contents and the write is stored.
- R10: During and after reset, both interrupt lines are high, `clash` is low and both read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write strobe (with l_en) |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| l_irq_n | output | 1 | Left interrupt, active low, set by the right port |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write strobe (with r_en) |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |
| r_irq_n | output | 1 | Right interrupt, active low, set by the left port |
| clash | output | 1 | One-cycle pulse on a same-address conflict involving a write |

## Verification
Every result of this block is due exactly one clock edge after the cycle that presents the access: read data, both interrupt levels and the conflict pulse. The bench drives each access just after an edge and samples one time unit after the next edge. It then returns the ports to idle, so a second sample one edge later shows that read data holds and that `clash` has dropped. Mailbox tests read the interrupt lines both in the cycle after the setting write and after the releasing access. This shows that the set and the release each land on their own edge.

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n,
  output logic              clash
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BOX_TO_R = '1;
  localparam logic [ADDR_W-1:0] BOX_TO_L = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [DATA_W-1:0] mem [DEPTH];

  wire l_wr    = l_en & l_we;
  wire r_wr    = r_en & r_we;
  wire same    = l_en & r_en & (l_addr == r_addr);
  wire collide = same & (l_wr | r_wr);

  wire set_r = l_wr & (l_addr == BOX_TO_R);
  wire clr_r = r_en & (r_addr == BOX_TO_R);
  wire set_l = r_wr & (r_addr == BOX_TO_L);
  wire clr_l = l_en & (l_addr == BOX_TO_L);

  always_ff @(posedge clk) begin
    if (l_wr) mem[l_addr] <= l_wdata;
    if (r_wr && !(l_wr && same)) mem[r_addr] <= r_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_en && !l_we) l_rdata <= mem[l_addr];
      if (r_en && !r_we) r_rdata <= mem[r_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_irq_n <= 1'b1;
      l_irq_n <= 1'b1;
      clash   <= 1'b0;
    end else begin
      if (set_r)      r_irq_n <= 1'b0;
      else if (clr_r) r_irq_n <= 1'b1;
      if (set_l)      l_irq_n <= 1'b0;
      else if (clr_l) l_irq_n <= 1'b1;
      clash <= collide;
    end
  end
endmodule

// File: rtl/dpram_mailbox_chk.sv
module dpram_mailbox_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en,
  input logic              l_we,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_irq_n,
  input logic              r_en,
  input logic              r_we,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_irq_n,
  input logic              clash
);
  localparam logic [ADDR_W-1:0] TOP  = '1;
  localparam logic [ADDR_W-1:0] TOP1 = {{(ADDR_W-1){1'b1}}, 1'b0};

  // R1
  l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && !l_we) |=> $stable(l_rdata));
  // R1
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_en && !r_we) |=> $stable(r_rdata));
  // R3
  r_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_we && l_addr == TOP) |=> !r_irq_n);
  // R4
  r_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_addr == TOP && !(l_en && l_we && l_addr == TOP)) |=> r_irq_n);
  // R5
  l_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_we && r_addr == TOP1) |=> !l_irq_n);
  // R6
  l_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_addr == TOP1 && !(r_en && r_we && r_addr == TOP1)) |=> l_irq_n);
  // R4
  r_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_irq_n) |-> $past(r_en && r_addr == TOP));
  // R8
  clash_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && r_en && l_addr == r_addr && (l_we || r_we)) |=> clash);
  // R8
  clash_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && r_en && l_addr == r_addr && (l_we || r_we)) |=> !clash);
endmodule

bind dpram_mailbox dpram_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/dpram_mailbox_tb_top.sv
module dpram_mailbox_tb_top;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam logic [AW-1:0] TOP  = '1;
  localparam logic [AW-1:0] TOP1 = TOP - 11'd1;

  logic clk = 0, rst_n = 0;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n, clash;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(); l_en = 0; l_we = 0; r_en = 0; r_we = 0; endtask

  task automatic lw(logic [AW-1:0] a, logic [DW-1:0] d);
    l_en = 1; l_we = 1; l_addr = a; l_wdata = d; step(); idle();
  endtask
  task automatic rw(logic [AW-1:0] a, logic [DW-1:0] d);
    r_en = 1; r_we = 1; r_addr = a; r_wdata = d; step(); idle();
  endtask
  task automatic lr(logic [AW-1:0] a);
    l_en = 1; l_we = 0; l_addr = a; step(); idle();
  endtask
  task automatic rr(logic [AW-1:0] a);
    r_en = 1; r_we = 0; r_addr = a; step(); idle();
  endtask

  task automatic t_reset();
    step(); step();
    chk("R10 l_irq_n", l_irq_n, 1); chk("R10 r_irq_n", r_irq_n, 1);
    chk("R10 clash", clash, 0);
    chk("R10 l_rdata", l_rdata, 0); chk("R10 r_rdata", r_rdata, 0);
    rst_n = 1; step();
  endtask

  task automatic t_storage();
    lw(11'd5, 16'hA5C3); rr(11'd5); chk("R1 cross read", r_rdata, 16'hA5C3);
    rw(11'd6, 16'h1234); lr(11'd6); chk("R1 cross read", l_rdata, 16'h1234);
    step(); chk("R1 hold", l_rdata, 16'h1234);
    lw(11'd6, 16'h0F0F); chk("R1 hold on write", l_rdata, 16'h1234);
  endtask

  task automatic t_dual_read();
    l_en = 1; r_en = 1; l_addr = 11'd5; r_addr = 11'd5; step(); idle();
    chk("R2 left", l_rdata, 16'hA5C3); chk("R2 right", r_rdata, 16'hA5C3);
    chk("R2 no clash", clash, 0);
  endtask

  task automatic t_box_right();
    lw(TOP, 16'h0000); chk("R3 set by zero", r_irq_n, 0); chk("R3 other", l_irq_n, 1);
    step(); chk("R3 stays", r_irq_n, 0);
    rr(TOP); chk("R4 read clears", r_irq_n, 1); chk("R4 data", r_rdata, 16'h0000);
    lw(TOP, 16'h0007); chk("R3 set", r_irq_n, 0);
    rw(TOP, 16'h0000); chk("R4 write clears", r_irq_n, 1);
  endtask

  task automatic t_box_left();
    rw(TOP1, 16'h0000); chk("R5 set by zero", l_irq_n, 0); chk("R5 other", r_irq_n, 1);
    lw(TOP1, 16'h0000); chk("R6 write clears", l_irq_n, 1);
    rw(TOP1, 16'h0042); chk("R5 set", l_irq_n, 0);
    lr(TOP1); chk("R6 read clears", l_irq_n, 1); chk("R6 data", l_rdata, 16'h0042);
  endtask

  task automatic t_priority();
    l_en = 1; l_we = 1; l_addr = TOP; l_wdata = 16'h0009;
    r_en = 1; r_we = 0; r_addr = TOP; step(); idle();
    chk("R7 right set wins", r_irq_n, 0); chk("R8 clash", clash, 1);
    chk("R9 reader old", r_rdata, 16'h0000);
    step(); chk("R8 one cycle", clash, 0);
    rr(TOP); chk("R4 clear", r_irq_n, 1); chk("R9 write stored", r_rdata, 16'h0009);
    l_en = 1; l_we = 0; l_addr = TOP1;
    r_en = 1; r_we = 1; r_addr = TOP1; r_wdata = 16'h0003; step(); idle();
    chk("R7 left set wins", l_irq_n, 0); chk("R8 clash", clash, 1);
    lr(TOP1); chk("R6 clear", l_irq_n, 1);
  endtask

  task automatic t_clash();
    l_en = 1; l_we = 1; l_addr = 11'd9; l_wdata = 16'hAAAA;
    r_en = 1; r_we = 1; r_addr = 11'd9; r_wdata = 16'h5555; step(); idle();
    chk("R8 ww clash", clash, 1);
    rr(11'd9); chk("R8 pulse ends", clash, 0); chk("R9 left wins", r_rdata, 16'hAAAA);
    lw(11'd10, 16'h1111);
    l_en = 1; l_we = 0; l_addr = 11'd10;
    r_en = 1; r_we = 1; r_addr = 11'd10; r_wdata = 16'h2222; step(); idle();
    chk("R8 rw clash", clash, 1); chk("R9 reader old", l_rdata, 16'h1111);
    lr(11'd10); chk("R9 right write stored", l_rdata, 16'h2222);
    l_en = 1; l_we = 1; l_addr = 11'd20; l_wdata = 16'hBEEF;
    r_en = 1; r_we = 1; r_addr = 11'd21; r_wdata = 16'hCAFE; step(); idle();
    chk("R8 distinct no clash", clash, 0);
    lr(11'd21); chk("R1 right stored", l_rdata, 16'hCAFE);
    rr(11'd20); chk("R1 left stored", r_rdata, 16'hBEEF);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    t_reset();
    t_storage();
    t_dual_read();
    t_box_right();
    t_box_left();
    t_priority();
    t_clash();
    finish_up();
  end
endmodule